// File: doc/BRIEF.md
# Color-Keyed Two-Plane Pixel Mixer

This block merges two RGB pixel streams that arrive together, one pixel per plane per cycle, into a single output pixel. A weight for each plane is taken from either plane's alpha byte or from a programmed constant. The two weights are combined with a rounded divide by the full-scale value, and the result saturates at full scale. A swap control inverts which plane gets the complement of its weight.

An optional color-key comparator tests one chosen plane against a programmed key color. The comparison can ignore up to three low bits of each channel. A 3-bit mode turns the hit or miss result into the pixel that goes out: the blended value, raw plane 1 or raw plane 2. All configuration inputs are static levels, and they are sampled together with the pixel in the first pipeline stage. A valid flag travels with each pixel through a fixed two-register pipeline.

Top module: `plane_mixer`

## Requirements
- R1: Weight select code 0 takes plane 1's alpha and code 1 takes plane 2's alpha. Codes 2 and 3 take the fixed value: the source select uses the source fixed weight, and the destination select uses the destination fixed weight.
- R2: With swap clear, the plane 1 weight is w1 = Ws and the plane 2 weight is w2 = 255 − Wd. With swap set, w1 = 255 − Ws and w2 = Wd. Each channel (R at bits 23:16, G at 15:8, B at 7:0) is min(255, floor((c1·w1 + c2·w2 + 127)/255)).
- R3: With keying enabled, the tested plane (select 0 = plane 1, 1 = plane 2) hits when R, G and B each equal the key in their top 8 − d bits. Depth code d is 0, 1, 2 or 3, which compares 8, 7, 6 or 5 bits.
- R4: The mode gives the output for (miss, hit) as follows: 0 and 1 give (blend, blend), 2 gives (blend, plane1), 3 gives (plane1, blend), 4 gives (blend, plane2), 5 gives (plane2, blend), 6 gives (plane1, plane2) and 7 gives (plane2, plane1). A pass-through outputs the raw plane pixel.
- R5: With keying disabled, the output is the blended value whatever the mode and key.
- R6: A pixel presented with in_valid before clock edge k appears on out_pix with out_valid high after edge k+1. out_valid is low in every other cycle.
- R7: out_pix holds its last value while no valid pixel leaves the pipeline.
- R8: While rst_n is low, out_valid and out_pix are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel pair is valid |
| p1_pix | input | 24 | Plane 1 RGB pixel |
| p1_alpha | input | 8 | Plane 1 alpha |
| p2_pix | input | 24 | Plane 2 RGB pixel |
| p2_alpha | input | 8 | Plane 2 alpha |
| cfg_wsel_src | input | 2 | Source weight select |
| cfg_wsel_dst | input | 2 | Destination weight select |
| cfg_fix_src | input | 8 | Source fixed weight |
| cfg_fix_dst | input | 8 | Destination fixed weight |
| cfg_swap | input | 1 | Weight pairing swap |
| cfg_key_en | input | 1 | Color key enable |
| cfg_key_plane | input | 1 | Plane tested against key |
| cfg_key_depth | input | 2 | Key comparison depth code |
| cfg_key_color | input | 24 | Key RGB color |
| cfg_key_mode | input | 3 | Miss/hit output pairing |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 24 | Output RGB pixel |

## Verification
The bench builds the mixer with its default 8-bit channels and three channels. At this size every depth code leaves at least five compared bits, so all four codes can be told apart by flipping the lowest compared bit. The combined weight can reach 510, which makes the saturation clamp reachable. Every mode is paired with every depth on both a near-hit and a near-miss pixel, on alternating tested planes.

// File: rtl/mix_pkg.sv
package mix_pkg;

  localparam int WSEL_W  = 2;
  localparam int DEPTH_W = 2;
  localparam int MODE_W  = 3;

  typedef enum logic [1:0] {
    SRC_BLEND = 2'd0,
    SRC_P1    = 2'd1,
    SRC_P2    = 2'd2
  } src_e;

  typedef struct packed {
    src_e on_miss;
    src_e on_hit;
  } pair_t;

  function automatic pair_t mode_pair(input logic [MODE_W-1:0] m);
    pair_t p;
    case (m)
      3'd2:    p = '{on_miss: SRC_BLEND, on_hit: SRC_P1};
      3'd3:    p = '{on_miss: SRC_P1,    on_hit: SRC_BLEND};
      3'd4:    p = '{on_miss: SRC_BLEND, on_hit: SRC_P2};
      3'd5:    p = '{on_miss: SRC_P2,    on_hit: SRC_BLEND};
      3'd6:    p = '{on_miss: SRC_P1,    on_hit: SRC_P2};
      3'd7:    p = '{on_miss: SRC_P2,    on_hit: SRC_P1};
      default: p = '{on_miss: SRC_BLEND, on_hit: SRC_BLEND};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mix_weight_sel.sv
module mix_weight_sel
  import mix_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [WSEL_W-1:0] sel_src,
  input  logic [WSEL_W-1:0] sel_dst,
  input  logic [CW-1:0]     alpha1,
  input  logic [CW-1:0]     alpha2,
  input  logic [CW-1:0]     fix_src,
  input  logic [CW-1:0]     fix_dst,
  input  logic              swap,
  output logic [CW-1:0]     w1,
  output logic [CW-1:0]     w2
);

  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic [CW-1:0] ws;
  logic [CW-1:0] wd;

  function automatic logic [CW-1:0] pick(input logic [WSEL_W-1:0] s,
                                         input logic [CW-1:0] a1,
                                         input logic [CW-1:0] a2,
                                         input logic [CW-1:0] fx);
    case (s)
      2'd0:    return a1;
      2'd1:    return a2;
      default: return fx;
    endcase
  endfunction

  always_comb begin
    ws = pick(sel_src, alpha1, alpha2, fix_src);
    wd = pick(sel_dst, alpha1, alpha2, fix_dst);
    if (swap) begin
      w1 = FULL - ws;
      w2 = wd;
    end else begin
      w1 = ws;
      w2 = FULL - wd;
    end
  end

  // Same weight source on both sides means the pair always spans full scale.
  always_comb begin
    if (sel_src == sel_dst && sel_src < 2'd2)
      assert_pair_full_R2: assert ({1'b0, w1} + {1'b0, w2} == {1'b0, FULL})
        else $error("weight pair does not sum to full scale");
  end

endmodule

// File: rtl/mix_key_cmp.sv
module mix_key_cmp
  import mix_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NCH = 3
) (
  input  logic               key_en,
  input  logic               key_plane,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [CW*NCH-1:0]  pix1,
  input  logic [CW*NCH-1:0]  pix2,
  input  logic [CW*NCH-1:0]  key,
  output logic               hit
);

  localparam int PW   = CW * NCH;
  localparam int MINB = CW - 3;

  logic [PW-1:0]  tested;
  logic [CW-1:0]  mask;
  logic [NCH-1:0] ch_eq;

  assign tested = key_plane ? pix2 : pix1;
  assign mask   = {CW{1'b1}} << depth;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_eq[i] = ((tested[i*CW +: CW] ^ key[i*CW +: CW]) & mask) == '0;
  end

  assign hit = key_en & (&ch_eq);

  // A hit at any depth implies agreement on the upper bits that are always compared.
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (hit)
        assert_hit_msb_R3: assert (tested[c*CW+3 +: MINB] == key[c*CW+3 +: MINB])
          else $error("key hit with mismatched upper bits");
    end
  end

endmodule

// File: rtl/mix_blend_ch.sv
module mix_blend_ch #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] c1,
  input  logic [CW-1:0] c2,
  input  logic [CW-1:0] w1,
  input  logic [CW-1:0] w2,
  output logic [CW-1:0] res
);

  localparam int SW   = 2 * CW + 2;
  localparam int MAXV = (1 << CW) - 1;

  logic [SW-1:0] acc;
  logic [SW-1:0] quo;

  always_comb begin
    acc = SW'(c1) * SW'(w1) + SW'(c2) * SW'(w2) + SW'(MAXV / 2);
    quo = acc / SW'(MAXV);
    res = (quo > SW'(MAXV)) ? CW'(MAXV) : quo[CW-1:0];
  end

  // Complementary weights give a rounded average that stays between the two inputs.
  always_comb begin
    if ({1'b0, w1} + {1'b0, w2} == (CW+1)'(MAXV))
      assert_between_R2: assert (res >= ((c1 < c2) ? c1 : c2) && res <= ((c1 > c2) ? c1 : c2))
        else $error("blend outside input range");
  end

endmodule

// File: rtl/plane_mixer.sv
module plane_mixer
  import mix_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NCH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CW*NCH-1:0]   p1_pix,
  input  logic [CW-1:0]       p1_alpha,
  input  logic [CW*NCH-1:0]   p2_pix,
  input  logic [CW-1:0]       p2_alpha,
  input  logic [WSEL_W-1:0]   cfg_wsel_src,
  input  logic [WSEL_W-1:0]   cfg_wsel_dst,
  input  logic [CW-1:0]       cfg_fix_src,
  input  logic [CW-1:0]       cfg_fix_dst,
  input  logic                cfg_swap,
  input  logic                cfg_key_en,
  input  logic                cfg_key_plane,
  input  logic [DEPTH_W-1:0]  cfg_key_depth,
  input  logic [CW*NCH-1:0]   cfg_key_color,
  input  logic [MODE_W-1:0]   cfg_key_mode,
  output logic                out_valid,
  output logic [CW*NCH-1:0]   out_pix
);

  localparam int PW = CW * NCH;

  // ---------------- stage 1: weights, key, choice ----------------
  logic [CW-1:0] w1_c, w2_c;
  logic          hit_c;
  pair_t         pair_c;
  src_e          choice_c;

  mix_weight_sel #(.CW(CW)) u_wsel (
    .sel_src (cfg_wsel_src),
    .sel_dst (cfg_wsel_dst),
    .alpha1  (p1_alpha),
    .alpha2  (p2_alpha),
    .fix_src (cfg_fix_src),
    .fix_dst (cfg_fix_dst),
    .swap    (cfg_swap),
    .w1      (w1_c),
    .w2      (w2_c)
  );

  mix_key_cmp #(.CW(CW), .NCH(NCH)) u_key (
    .key_en    (cfg_key_en),
    .key_plane (cfg_key_plane),
    .depth     (cfg_key_depth),
    .pix1      (p1_pix),
    .pix2      (p2_pix),
    .key       (cfg_key_color),
    .hit       (hit_c)
  );

  always_comb begin
    pair_c = mode_pair(cfg_key_mode);
    if (!cfg_key_en)  choice_c = SRC_BLEND;
    else if (hit_c)   choice_c = pair_c.on_hit;
    else              choice_c = pair_c.on_miss;
  end

  logic          s1_valid, s1_valid_d;
  logic [PW-1:0] s1_p1,    s1_p1_d;
  logic [PW-1:0] s1_p2,    s1_p2_d;
  logic [CW-1:0] s1_w1,    s1_w1_d;
  logic [CW-1:0] s1_w2,    s1_w2_d;
  src_e          s1_choice, s1_choice_d;

  always_comb begin
    s1_valid_d  = in_valid;
    s1_p1_d     = s1_p1;
    s1_p2_d     = s1_p2;
    s1_w1_d     = s1_w1;
    s1_w2_d     = s1_w2;
    s1_choice_d = s1_choice;
    if (in_valid) begin
      s1_p1_d     = p1_pix;
      s1_p2_d     = p2_pix;
      s1_w1_d     = w1_c;
      s1_w2_d     = w2_c;
      s1_choice_d = choice_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_p1     <= '0;
      s1_p2     <= '0;
      s1_w1     <= '0;
      s1_w2     <= '0;
      s1_choice <= SRC_BLEND;
    end else begin
      s1_valid  <= s1_valid_d;
      s1_p1     <= s1_p1_d;
      s1_p2     <= s1_p2_d;
      s1_w1     <= s1_w1_d;
      s1_w2     <= s1_w2_d;
      s1_choice <= s1_choice_d;
    end
  end

  // ---------------- stage 2: blend and select ----------------
  logic [PW-1:0] blend_pix;

  for (genvar i = 0; i < NCH; i++) begin : g_blend
    mix_blend_ch #(.CW(CW)) u_ch (
      .c1  (s1_p1[i*CW +: CW]),
      .c2  (s1_p2[i*CW +: CW]),
      .w1  (s1_w1),
      .w2  (s1_w2),
      .res (blend_pix[i*CW +: CW])
    );
  end

  logic          out_valid_d;
  logic [PW-1:0] sel_pix;
  logic [PW-1:0] out_pix_d;

  always_comb begin
    case (s1_choice)
      SRC_P1:  sel_pix = s1_p1;
      SRC_P2:  sel_pix = s1_p2;
      default: sel_pix = blend_pix;
    endcase
    out_valid_d = s1_valid;
    out_pix_d   = s1_valid ? sel_pix : out_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= out_valid_d;
      out_pix   <= out_pix_d;
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid) else $error("valid lost in pipeline");

  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid) else $error("spurious output valid");

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_pix)) else $error("output changed without valid");

  assert_pass_p1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_choice == SRC_P1 |=> out_pix == $past(s1_p1))
    else $error("plane 1 pass-through mismatch");

  assert_pass_p2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_choice == SRC_P2 |=> out_pix == $past(s1_p2))
    else $error("plane 2 pass-through mismatch");

  assert_key_off_blend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !cfg_key_en |=> s1_choice == SRC_BLEND)
    else $error("pass-through chosen with keying off");

endmodule

// File: tb/plane_mixer_tb.sv
module plane_mixer_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] p1;
    logic [7:0]  a1;
    logic [23:0] p2;
    logic [7:0]  a2;
    logic [1:0]  ssel;
    logic [1:0]  dsel;
    logic [7:0]  sfix;
    logic [7:0]  dfix;
    logic        swap;
    logic        ken;
    logic        kpl;
    logic [1:0]  kdep;
    logic [23:0] key;
    logic [2:0]  mode;
    logic [23:0] expv;
  } vec_t;

  localparam int NVEC = 9;
  // p1, a1, p2, a2, ssel, dsel, sfix, dfix, swap, ken, kpl, kdep, key, mode, expected
  localparam vec_t TABLE [NVEC] = '{
    '{24'hFFFFFF, 8'h00, 24'h000000, 8'h00, 2'd2, 2'd2, 8'd128, 8'd128, 1'b0, 1'b0, 1'b0, 2'd0, 24'h000000, 3'd0, 24'h808080}, // R1 R2 fixed
    '{24'hFFFFFF, 8'h00, 24'h000000, 8'h00, 2'd2, 2'd2, 8'd128, 8'd128, 1'b1, 1'b0, 1'b0, 2'd0, 24'h000000, 3'd0, 24'h7F7F7F}, // R2 swap
    '{24'h123456, 8'hFF, 24'hABCDEF, 8'h00, 2'd0, 2'd0, 8'd0,   8'd0,   1'b0, 1'b0, 1'b0, 2'd0, 24'h000000, 3'd0, 24'h123456}, // R1 plane1 alpha
    '{24'h123456, 8'hFF, 24'hABCDEF, 8'h00, 2'd1, 2'd1, 8'd0,   8'd0,   1'b0, 1'b0, 1'b0, 2'd0, 24'h000000, 3'd0, 24'hABCDEF}, // R1 plane2 alpha
    '{24'hC8C8C8, 8'h00, 24'hC8C8C8, 8'h00, 2'd3, 2'd2, 8'd255, 8'd0,   1'b0, 1'b0, 1'b0, 2'd0, 24'h000000, 3'd0, 24'hFFFFFF}, // R2 saturation
    '{24'h123456, 8'h00, 24'hABCDEF, 8'h00, 2'd2, 2'd2, 8'd0,   8'd0,   1'b0, 1'b1, 1'b0, 2'd0, 24'h123456, 3'd6, 24'hABCDEF}, // R3 R4 exact hit
    '{24'h123457, 8'h00, 24'hABCDEF, 8'h00, 2'd2, 2'd2, 8'd0,   8'd0,   1'b0, 1'b1, 1'b0, 2'd0, 24'h123456, 3'd6, 24'h123457}, // R3 R4 miss
    '{24'hFEDCBA, 8'h00, 24'h153351, 8'h00, 2'd2, 2'd2, 8'd0,   8'd0,   1'b0, 1'b1, 1'b1, 2'd3, 24'h123456, 3'd7, 24'hFEDCBA}, // R3 depth 5 bits
    '{24'h123456, 8'h00, 24'hABCDEF, 8'h00, 2'd2, 2'd2, 8'd0,   8'd0,   1'b0, 1'b0, 1'b0, 2'd0, 24'h123456, 3'd7, 24'hABCDEF}  // R5 key off
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] p1_pix = '0, p2_pix = '0, cfg_key_color = '0;
  logic [7:0]  p1_alpha = '0, p2_alpha = '0, cfg_fix_src = '0, cfg_fix_dst = '0;
  logic [1:0]  cfg_wsel_src = '0, cfg_wsel_dst = '0, cfg_key_depth = '0;
  logic        cfg_swap = 1'b0, cfg_key_en = 1'b0, cfg_key_plane = 1'b0;
  logic [2:0]  cfg_key_mode = '0;
  logic        out_valid;
  logic [23:0] out_pix;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plane_mixer u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .p1_pix (p1_pix), .p1_alpha (p1_alpha), .p2_pix (p2_pix), .p2_alpha (p2_alpha),
    .cfg_wsel_src (cfg_wsel_src), .cfg_wsel_dst (cfg_wsel_dst),
    .cfg_fix_src (cfg_fix_src), .cfg_fix_dst (cfg_fix_dst), .cfg_swap (cfg_swap),
    .cfg_key_en (cfg_key_en), .cfg_key_plane (cfg_key_plane),
    .cfg_key_depth (cfg_key_depth), .cfg_key_color (cfg_key_color),
    .cfg_key_mode (cfg_key_mode), .out_valid (out_valid), .out_pix (out_pix)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic logic [23:0] model(input vec_t v);
    int ws, wd, w1, w2, s, m;
    logic [23:0] bl, tp;
    bit hit;
    ws = (v.ssel == 2'd0) ? int'(v.a1) : (v.ssel == 2'd1) ? int'(v.a2) : int'(v.sfix);
    wd = (v.dsel == 2'd0) ? int'(v.a1) : (v.dsel == 2'd1) ? int'(v.a2) : int'(v.dfix);
    w1 = v.swap ? 255 - ws : ws;
    w2 = v.swap ? wd : 255 - wd;
    for (int c = 0; c < 3; c++) begin
      s = (int'(v.p1[c*8 +: 8]) * w1 + int'(v.p2[c*8 +: 8]) * w2 + 127) / 255;
      if (s > 255) s = 255;
      bl[c*8 +: 8] = s[7:0];
    end
    tp = v.kpl ? v.p2 : v.p1;
    hit = v.ken;
    for (int c = 0; c < 3; c++)
      if ((tp[c*8 +: 8] >> v.kdep) != (v.key[c*8 +: 8] >> v.kdep)) hit = 1'b0;
    if (!v.ken) return bl;
    m = int'(v.mode);
    case (m)
      2: return hit ? v.p1 : bl;
      3: return hit ? bl : v.p1;
      4: return hit ? v.p2 : bl;
      5: return hit ? bl : v.p2;
      6: return hit ? v.p2 : v.p1;
      7: return hit ? v.p1 : v.p2;
      default: return bl;
    endcase
  endfunction

  // Drive at a falling edge, hold one cycle, result readable two falling edges later.
  task automatic drive(input vec_t v);
    @(negedge clk);
    p1_pix = v.p1; p1_alpha = v.a1; p2_pix = v.p2; p2_alpha = v.a2;
    cfg_wsel_src = v.ssel; cfg_wsel_dst = v.dsel;
    cfg_fix_src = v.sfix; cfg_fix_dst = v.dfix; cfg_swap = v.swap;
    cfg_key_en = v.ken; cfg_key_plane = v.kpl; cfg_key_depth = v.kdep;
    cfg_key_color = v.key; cfg_key_mode = v.mode;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 not early", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
  endtask

  task automatic run(input string req, input vec_t v, input logic [23:0] exp);
    drive(v);
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {8'd0, out_pix}, {8'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    logic [23:0] hold;
    // R8 reset state
    repeat (3) @(negedge clk);
    check("R8 valid", {31'd0, out_valid}, 32'd0);
    check("R8 pix", {8'd0, out_pix}, 32'd0);
    rst_n = 1'b1;

    // Table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++)
      run("R1 R2 R3 R4 R5 table", TABLE[i], TABLE[i].expv);

    // Every mode at every depth, near-hit and near-miss: R3 R4
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 4; d++) begin
        for (int h = 0; h < 2; h++) begin
          logic [7:0] flip;
          logic [23:0] tp;
          flip = h ? 8'((1 << d) - 1) : 8'(1 << d);
          tp = 24'h6B92D4 ^ {flip, flip, flip};
          v = '0;
          v.key = 24'h6B92D4; v.ken = 1'b1; v.kdep = 2'(d); v.mode = 3'(m);
          v.kpl = 1'((m + d) % 2);
          v.ssel = 2'd0; v.dsel = 2'd1; v.a1 = 8'd90; v.a2 = 8'd60;
          v.p1 = v.kpl ? 24'h31C708 : tp;
          v.p2 = v.kpl ? tp : 24'h31C708;
          run(h ? "R3 R4 sweep hit" : "R3 R4 sweep miss", v, model(v));
        end
      end
    end

    // R7: output holds with no valid traffic
    hold = out_pix;
    @(negedge clk);
    p1_pix = 24'h000000; p2_pix = 24'hFFFFFF; cfg_key_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 hold", {8'd0, out_pix}, {8'd0, hold});
    check("R7 valid low", {31'd0, out_valid}, 32'd0);

    // R6: back-to-back pixels, each appearing two edges later
    @(negedge clk);
    v = TABLE[2];
    p1_pix = v.p1; p1_alpha = v.a1; p2_pix = v.p2; p2_alpha = v.a2;
    cfg_wsel_src = v.ssel; cfg_wsel_dst = v.dsel; cfg_swap = 1'b0; cfg_key_en = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    p1_alpha = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 first", {8'd0, out_pix}, {8'd0, 24'h123456});
    check("R6 first valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R6 second", {8'd0, out_pix}, {8'd0, 24'hABCDEF});
    check("R6 second valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R6 drained", {31'd0, out_valid}, 32'd0);

    // R8: reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R8 async valid", {31'd0, out_valid}, 32'd0);
    check("R8 async pix", {8'd0, out_pix}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule